// File: doc/BRIEF.md
# Binary-Indexed Carry Tree Adder

This block adds two unsigned operands of a power-of-two width with a carry tree instead of a ripple chain. There is one tree node per bit, numbered 1 to WIDTH. Every odd-numbered node is a leaf that owns two adjacent bit slices. Every even-numbered node merges two subtrees, and node WIDTH is the root.

A node finds its parent from its own number. Take the lowest set bit of the index as the node's level. If the bit just above it is set, the node is the upper child of `index - 2^level`. Otherwise it is the lower child of `index + 2^level`.

Generate and propagate pairs travel up the tree. Carries travel back down. Carry polarity on the downward wires alternates from one tree level to the next, and each node undoes it locally. The root injects a carry of zero. The sum, the per-bit carries and the carry-out are captured in one output register that has a synchronous active-low reset.

Top module: `cptree_adder`

## Requirements
- R1: One clock edge after inputs are sampled with `rst_n` high, `sum` equals `(op_a + op_b)` modulo 2^WIDTH.
- R2: One clock edge after inputs are sampled with `rst_n` high, `cout` equals bit WIDTH of the (WIDTH+1)-bit sum `op_a + op_b`.
- R3: One edge after sampling, `carry[i]` is the carry into bit i. It equals bit i of `(op_a + op_b) ^ op_a ^ op_b`, so `carry[0]` is always 0 because no external carry enters.
- R4: A clock edge with `rst_n` low drives `sum`, `carry` and `cout` to zero, whatever the operands are.
- R5: A carry generated at bit 0 must reach every higher bit. All-ones plus one yields a zero `sum`, `cout` of 1, and `carry` equal to all ones except bit 0.
- R6: When no bit position generates, because `op_a & op_b` is zero, every bit of `carry` is 0 and `cout` is 0. For example, alternating patterns 0101... and 1010... give a `sum` of all ones.
- R7: The result depends only on the operands of the previous edge. Back-to-back operand pairs each produce their own result in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sum | output | WIDTH | Registered sum |
| carry | output | WIDTH | Registered carry into each bit |
| cout | output | 1 | Registered carry out of the top bit |

## Verification
All three results (`sum`, `carry`, `cout`) are due exactly one rising edge after the operands are sampled: the tree is combinational and a single register follows it. The bench changes operands on the falling edge, lets one rising edge capture them, and reads the outputs on the next falling edge. It then presents the next pair on that same falling edge, so every cycle carries a fresh vector. The checker's properties relate each output to the operands one edge earlier.

// File: rtl/cptree_pkg.sv
// Package cptree_pkg
// Index arithmetic for the binary-indexed carry tree. Nodes are numbered
// from 1; index 0 is not a node. Every function is a constant function
// used at elaboration time.
package cptree_pkg;

    // Level of a node: position of the lowest set bit of its index.
    function automatic int node_level(input int idx);
        node_level = 0;
        for (int b = 30; b >= 0; b--) begin
            if (((idx >> b) & 1) == 1) node_level = b;
        end
    endfunction

    // 1 when the bit just above the level bit is set (node is an upper child).
    function automatic bit node_upper(input int idx);
        node_upper = (((idx >> (node_level(idx) + 1)) & 1) == 1);
    endfunction

    // Parent index derived from the level bit and the bit above it.
    function automatic int node_parent(input int idx);
        if (node_upper(idx)) node_parent = idx - (1 << node_level(idx));
        else                 node_parent = idx + (1 << node_level(idx));
    endfunction

    // Downward carry entering a node of this level arrives inverted when level is even.
    function automatic bit carry_in_inverted(input int lvl);
        carry_in_inverted = ((lvl % 2) == 0);
    endfunction

endpackage

// File: rtl/cptree_pair.sv
// Module cptree_pair
// Bit-slice pair served by one leaf of the tree. It forms generate and
// propagate for two adjacent bits and the two sum bits from the carries the
// leaf returns. Assumes the carries arrive in true polarity.
module cptree_pair (
    input  logic [1:0] a,
    input  logic [1:0] b,
    input  logic [1:0] c,
    output logic [1:0] g,
    output logic [1:0] p,
    output logic [1:0] s
);

    // Per-bit generate, propagate and sum.
    always_comb begin
        g = a & b;
        p = a ^ b;
        s = p ^ c;
    end

endmodule

// File: rtl/cptree_node.sv
// Module cptree_node
// Interior or leaf node of the carry tree. It merges the (g,p) of its lower
// child (0) and upper child (1) into one upward pair. It returns the incoming
// carry to the lower child and the carry out of the lower child to the upper
// child. IN_INV says the incoming carry is complemented; OUT_INV says both
// outgoing carries must be complemented. Assumes the parent honours
// the same convention.
module cptree_node #(
    parameter bit IN_INV  = 1'b0,
    parameter bit OUT_INV = 1'b0
) (
    input  logic g0,
    input  logic p0,
    input  logic g1,
    input  logic p1,
    input  logic c_in,
    output logic g,
    output logic p,
    output logic c0,
    output logic c1
);

    logic c_true;
    logic lo_true;
    logic hi_true;

    // Upward merge of the two child pairs.
    always_comb begin
        g = g1 | (p1 & g0);
        p = p1 & p0;
    end

    // Restore true polarity of the incoming carry.
    if (IN_INV) begin : g_in_inv
        assign c_true = ~c_in;
    end else begin : g_in_true
        assign c_true = c_in;
    end

    // Carries for the two children in true polarity.
    always_comb begin
        lo_true = c_true;
        hi_true = g0 | (p0 & c_true);
    end

    // Apply the polarity the children expect.
    if (OUT_INV) begin : g_out_inv
        assign c0 = ~lo_true;
        assign c1 = ~hi_true;
    end else begin : g_out_true
        assign c0 = lo_true;
        assign c1 = hi_true;
    end

endmodule

// File: rtl/cptree_root.sv
// Module cptree_root
// Root node of the tree. It has only a lower child, injects a constant zero
// carry, and produces the carry out of the whole word. CHILD_INV selects
// the polarity in which the child expects its carry.
module cptree_root #(
    parameter bit CHILD_INV = 1'b0
) (
    input  logic g0,
    input  logic p0,
    output logic c0,
    output logic cout
);

    localparam logic ROOT_CARRY = 1'b0;

    // Word carry-out from the single child's group pair.
    assign cout = g0 | (p0 & ROOT_CARRY);

    // Carry sent down, in the child's polarity.
    if (CHILD_INV) begin : g_inv
        assign c0 = ~ROOT_CARRY;
    end else begin : g_true
        assign c0 = ROOT_CARRY;
    end

endmodule

// File: rtl/cptree_adder.sv
// Module cptree_adder
// WIDTH-bit adder built on a binary-indexed carry tree, with one registered
// output stage. Node i's parent comes from the bits of i; odd nodes are leaves
// serving bits i-1 and i; node WIDTH is the root with carry-in zero.
// Assumes WIDTH is a power of two and at least 4.
module cptree_adder #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum,
    output logic [WIDTH-1:0] carry,
    output logic             cout
);
    import cptree_pkg::*;

    localparam int ROOT_IDX = WIDTH;
    localparam int ROOT_LVL = $clog2(WIDTH);

    // Child-side port groups indexed by the node that owns them.
    logic k0_g [1:WIDTH];
    logic k0_p [1:WIDTH];
    logic k0_c [1:WIDTH];
    logic k1_g [1:WIDTH-1];
    logic k1_p [1:WIDTH-1];
    logic k1_c [1:WIDTH-1];
    // Upward group and incoming carry of each non-root node.
    logic up_g [1:WIDTH-1];
    logic up_p [1:WIDTH-1];
    logic dn_c [1:WIDTH-1];

    logic [WIDTH-1:0] sum_c;
    logic [WIDTH-1:0] carry_c;
    logic             cout_c;

    for (genvar i = 1; i <= WIDTH; i++) begin : g_node
        localparam int LV = node_level(i);
        if (i == ROOT_IDX) begin : g_root
            cptree_root #(
                .CHILD_INV (carry_in_inverted(ROOT_LVL - 1))
            ) u_root (
                .g0   (k0_g[i]),
                .p0   (k0_p[i]),
                .c0   (k0_c[i]),
                .cout (cout_c)
            );
        end else begin : g_inner
            localparam int PAR = node_parent(i);
            localparam bit UP  = node_upper(i);

            cptree_node #(
                .IN_INV  (carry_in_inverted(LV)),
                .OUT_INV (LV > 0 ? !carry_in_inverted(LV - 1) == 1'b0 : 1'b0)
            ) u_node (
                .g0   (k0_g[i]),
                .p0   (k0_p[i]),
                .g1   (k1_g[i]),
                .p1   (k1_p[i]),
                .c_in (dn_c[i]),
                .g    (up_g[i]),
                .p    (up_p[i]),
                .c0   (k0_c[i]),
                .c1   (k1_c[i])
            );

            // Hook this node onto the parent port group picked by its index bits.
            if (UP) begin : g_to_hi
                assign k1_g[PAR] = up_g[i];
                assign k1_p[PAR] = up_p[i];
                assign dn_c[i]   = k1_c[PAR];
            end else begin : g_to_lo
                assign k0_g[PAR] = up_g[i];
                assign k0_p[PAR] = up_p[i];
                assign dn_c[i]   = k0_c[PAR];
            end

            // Leaves own the bit-slice pair (i-1, i).
            if (LV == 0) begin : g_leaf
                logic [1:0] pg;
                logic [1:0] pp;
                logic [1:0] ps;

                cptree_pair u_pair (
                    .a (op_a[i:i-1]),
                    .b (op_b[i:i-1]),
                    .c ({k1_c[i], k0_c[i]}),
                    .g (pg),
                    .p (pp),
                    .s (ps)
                );

                assign k0_g[i]       = pg[0];
                assign k0_p[i]       = pp[0];
                assign k1_g[i]       = pg[1];
                assign k1_p[i]       = pp[1];
                assign sum_c[i-1]    = ps[0];
                assign sum_c[i]      = ps[1];
                assign carry_c[i-1]  = k0_c[i];
                assign carry_c[i]    = k1_c[i];
            end
        end
    end

    // Output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum   <= '0;
            carry <= '0;
            cout  <= 1'b0;
        end else begin
            sum   <= sum_c;
            carry <= carry_c;
            cout  <= cout_c;
        end
    end

endmodule

// File: rtl/cptree_adder_chk.sv
// Module cptree_adder_chk
// Property checker bound to cptree_adder. It relates the registered outputs
// to the operands one edge earlier.
module cptree_adder_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [WIDTH-1:0] sum,
    input logic [WIDTH-1:0] carry,
    input logic             cout
);

    // R1
    sum_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> sum == ($past(op_a) + $past(op_b)));

    // R2
    cout_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ({cout, sum} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)})));

    // R3
    carry_relation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> carry == (sum ^ $past(op_a) ^ $past(op_b)));

    // R3
    carry_lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry[0] == 1'b0);

    // R4
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (sum == '0 && carry == '0 && cout == 1'b0));

    // R6
    no_generate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && (op_a & op_b) == '0) |=> (carry == '0 && !cout));

endmodule

bind cptree_adder cptree_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op_a  (op_a),
    .op_b  (op_b),
    .sum   (sum),
    .carry (carry),
    .cout  (cout)
);

// File: tb/cptree_adder_test.sv
// Bench for cptree_adder: directed corners plus seeded random operands,
// compared against a behavioural sum computed here.
module cptree_adder_test;

    localparam int WIDTH      = 32;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 400;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] op_a = '0;
    logic [WIDTH-1:0] op_b = '0;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] carry;
    logic             cout;

    int checks = 0;
    int fails  = 0;

    cptree_adder #(.WIDTH(WIDTH)) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .op_a  (op_a),
        .op_b  (op_b),
        .sum   (sum),
        .carry (carry),
        .cout  (cout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural (WIDTH+1)-bit sum.
    function automatic logic [WIDTH:0] ref_sum(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
        ref_sum = {1'b0, a} + {1'b0, b};
    endfunction

    // Carry into each bit from the behavioural sum.
    function automatic logic [WIDTH-1:0] ref_carry(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
        logic [WIDTH:0] t;
        t = ref_sum(a, b);
        ref_carry = t[WIDTH-1:0] ^ a ^ b;
    endfunction

    // Compare one value and count the result.
    task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one operand pair and check all results one edge later.
    task automatic apply(input string tag, input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
        logic [WIDTH:0] e;
        e = ref_sum(a, b);
        op_a = a;
        op_b = b;
        @(posedge clk);
        @(negedge clk);
        check({tag, " R1 sum"}, sum, e[WIDTH-1:0]);
        check({tag, " R2 cout"}, {{(WIDTH-1){1'b0}}, cout}, {{(WIDTH-1){1'b0}}, e[WIDTH]});
        check({tag, " R3 carry"}, carry, ref_carry(a, b));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [WIDTH-1:0] ones;
        logic [WIDTH-1:0] alt01;
        ones  = '1;
        alt01 = {(WIDTH/2){2'b01}};
        void'($urandom(32'd1234));

        // R4: reset clears outputs even with busy operands.
        @(negedge clk);
        op_a = ones;
        op_b = ones;
        @(posedge clk);
        @(negedge clk);
        check("R4 sum in reset", sum, '0);
        check("R4 carry in reset", carry, '0);
        check("R4 cout in reset", {{(WIDTH-1){1'b0}}, cout}, '0);
        rst_n = 1'b1;

        apply("R1 zero", '0, '0);
        // R5: full-length propagation from bit 0.
        apply("R5 ones+1", ones, {{(WIDTH-1){1'b0}}, 1'b1});
        check("R5 carry all but bit0", carry, {ones[WIDTH-1:1], 1'b0});
        apply("R5 1+ones", {{(WIDTH-1){1'b0}}, 1'b1}, ones);
        apply("R2 ones+ones", ones, ones);
        // R6: alternating patterns generate nothing.
        apply("R6 alt", alt01, ~alt01);
        check("R6 alt sum all ones", sum, ones);
        check("R6 alt no carry", carry, '0);
        apply("R6 alt swap", ~alt01, alt01);
        apply("R2 msb only", {1'b1, {(WIDTH-1){1'b0}}}, {1'b1, {(WIDTH-1){1'b0}}});
        apply("R3 alt+alt", alt01, alt01);

        // R7: back-to-back random vectors, one per cycle.
        for (int k = 0; k < N_RANDOM; k++) begin
            apply("R7 random", $urandom, $urandom);
        end

        // R4: reset mid-stream after a non-zero result.
        apply("R1 pre-reset", ones, ones);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R4 sum after reset", sum, '0);
        check("R4 carry after reset", carry, '0);
        check("R4 cout after reset", {{(WIDTH-1){1'b0}}, cout}, '0);
        rst_n = 1'b1;
        apply("R7 after reset", alt01, ones);

        finish_run();
    end

endmodule